// File: doc/BRIEF.md
# PWM Peak Current-Limit Gate

This block produces one edge-aligned PWM signal and cuts its high phase short when an external comparator reports that a current threshold has been crossed. It is the conditioning logic that sits between a peak-current comparator and the power switch in a current-mode converter controller.

A free-running counter sets the switching period and the duty. A blanking counter starts each time the ungated PWM goes high, and it masks the comparator while switching transients settle. Outside that window, a trip from the comparator is captured in a latch. While the latch is set, the PWM output is held low. The latch releases only when two things have happened: the trip signal has fallen, and the PWM cycle has reached its last count. The output then resumes at the start of the next cycle. If the comparator is still high when the cycle ends, the latch stays set and the output stays low for the whole of the following cycle.

The comparator input is asynchronous. It passes through a two-flop synchroniser before any edge detection or qualification.

Top module: `peak_trip_pwm`

## Requirements
- R1: The period counter runs 0 up to `period`-1 and then wraps to 0. If `period` is 0 or 1, the counter stays at 0. The ungated PWM is high while the count is below `duty`. The last count of the period is the end of the cycle.
- R2: `blank_active` is high for exactly `blank_len` clocks. The first of these is the clock in which the ungated PWM goes from low to high. Blanking ends early if the ungated PWM goes low. A `blank_len` of 0 gives no blanking.
- R3: A synchronised trip that arrives while `blank_active` is high is ignored: `limit_active` stays low.
- R4: `trip_in` is taken without inversion through a two-flop synchroniser. If `trip_in` is high at clock edge k and blanking is off at edge k+2, `limit_active` is high after edge k+2.
- R5: Once set, `limit_active` stays high after `trip_in` returns low, until the end of the cycle.
- R6: A falling edge on the synchronised trip arms the release, and the arm is cleared at count 0. `limit_active` clears only at the last count of a cycle, and only if the release is armed.
- R7: `pwm_out` is the ungated PWM forced low while `limit_active` is high. After a release, `pwm_out` goes high again at count 0 of the next cycle.
- R8: If the synchronised trip is still high at the last count, `limit_active` stays set. `pwm_out` then stays low for the whole of the next cycle.
- R9: Reset clears the latch, the arm, the synchroniser and both counters. The first cycle after reset starts at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_in | input | 1 | Asynchronous comparator trip, active high |
| period | input | CNT_W | PWM period in clocks |
| duty | input | CNT_W | Clocks of high phase per period |
| blank_len | input | BLANK_W | Blanking length in clocks, 0 disables |
| pwm_out | output | 1 | Gated PWM output |
| limit_active | output | 1 | Current-limit latch state |
| blank_active | output | 1 | Leading-edge blanking window active |

## Verification
The bench applies four kinds of trip pattern, and each one separates a different part of the logic:
- A short trip that fits entirely inside the blanking window shows whether qualification works.
- A pulse placed mid-phase that falls well before the cycle ends shows whether the latch holds and releases at the cycle boundary.
- A trip held across the end of a cycle shows whether the latch refuses to release without a falling edge, and whether it then blanks a full cycle.
- A trip at count 0 with blanking set to zero, together with period and duty changes, shows whether the zero-length window and the counter wrap are handled correctly.

// File: rtl/peak_trip_pkg.sv
package peak_trip_pkg;
  localparam int CNT_W_DEF   = 16;
  localparam int BLANK_W_DEF = 16;

  // Last count of a cycle; periods of 0 or 1 collapse to a single count.
  function automatic logic [31:0] last_count(input logic [31:0] per);
    return (per <= 32'd1) ? 32'd0 : per - 32'd1;
  endfunction

  // Ungated PWM level for a given count.
  function automatic logic pwm_level(input logic [31:0] cnt, input logic [31:0] dty);
    return cnt < dty;
  endfunction

  // Reload value of the blanking counter when a window opens.
  function automatic logic [31:0] blank_reload(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction
endpackage

// File: rtl/ptp_period_cnt.sv
module ptp_period_cnt
  import peak_trip_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic             raw_pwm,
  output logic             eoc,
  output logic             cyc_start
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = CNT_W'(last_count(32'(period)));
  assign eoc       = (cnt_q >= last);
  assign cyc_start = (cnt_q == '0);
  assign raw_pwm   = pwm_level(32'(cnt_q), 32'(duty));
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (eoc) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptp_blank.sv
module ptp_blank
  import peak_trip_pkg::*;
#(
  parameter int BLANK_W = BLANK_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raw_pwm,
  input  logic [BLANK_W-1:0] blank_len,
  output logic               pwm_rise,
  output logic               blank_active
);
  logic               prev_q;
  logic [BLANK_W-1:0] left_q;

  assign pwm_rise     = raw_pwm & ~prev_q;
  assign blank_active = raw_pwm & (pwm_rise ? (blank_len != '0) : (left_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= raw_pwm;
      if (!raw_pwm)           left_q <= '0;
      else if (pwm_rise)      left_q <= BLANK_W'(blank_reload(32'(blank_len)));
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/ptp_trip_sync.sv
module ptp_trip_sync (
  input  logic clk,
  input  logic rst,
  input  logic trip_in,
  output logic trip_s,
  output logic trip_fall
);
  logic [1:0] stage_q;
  logic       last_q;

  assign trip_s    = stage_q[1];
  assign trip_fall = last_q & ~stage_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      last_q  <= 1'b0;
    end else begin
      stage_q <= {stage_q[0], trip_in};
      last_q  <= stage_q[1];
    end
  end
endmodule

// File: rtl/peak_trip_pwm.sv
module peak_trip_pwm
  import peak_trip_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int BLANK_W = BLANK_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trip_in,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   duty,
  input  logic [BLANK_W-1:0] blank_len,
  output logic               pwm_out,
  output logic               limit_active,
  output logic               blank_active
);
  logic [CNT_W-1:0] cnt;
  logic raw_pwm, eoc, cyc_start, pwm_rise;
  logic trip_s, trip_fall, accept;
  logic armed_q, limit_q;

  ptp_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .period(period), .duty(duty),
    .cnt(cnt), .raw_pwm(raw_pwm), .eoc(eoc), .cyc_start(cyc_start)
  );

  ptp_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk(clk), .rst(rst), .raw_pwm(raw_pwm), .blank_len(blank_len),
    .pwm_rise(pwm_rise), .blank_active(blank_active)
  );

  ptp_trip_sync u_sync (
    .clk(clk), .rst(rst), .trip_in(trip_in),
    .trip_s(trip_s), .trip_fall(trip_fall)
  );

  // Qualifier: trips count only outside the blanking window.
  assign accept = trip_s & ~blank_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      limit_q <= 1'b0;
    end else begin
      if (trip_fall)      armed_q <= 1'b1;
      else if (cyc_start) armed_q <= 1'b0;

      if (accept)              limit_q <= 1'b1;
      else if (eoc && armed_q) limit_q <= 1'b0;
    end
  end

  assign limit_active = limit_q;
  assign pwm_out      = raw_pwm & ~limit_q;
endmodule

// File: rtl/peak_trip_pwm_chk.sv
module peak_trip_pwm_chk (
  input logic clk,
  input logic rst,
  input logic eoc,
  input logic cyc_start,
  input logic armed_q,
  input logic trip_s,
  input logic pwm_out,
  input logic limit_active,
  input logic blank_active
);
  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    eoc |=> cyc_start);

  // R3
  blank_masks_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (!limit_active && blank_active) |=> !limit_active);

  // R5
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_active && !eoc) |=> limit_active);

  // R6
  release_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(limit_active) |-> ($past(eoc) && $past(armed_q)));

  // R7
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_active && !eoc) |=> !pwm_out);

  // R8
  stuck_trip_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_active && eoc && trip_s) |=> limit_active);
endmodule

bind peak_trip_pwm peak_trip_pwm_chk u_chk (
  .clk(clk), .rst(rst), .eoc(eoc), .cyc_start(cyc_start), .armed_q(armed_q),
  .trip_s(trip_s), .pwm_out(pwm_out), .limit_active(limit_active),
  .blank_active(blank_active)
);

// File: tb/peak_trip_pwm_bench.sv
module peak_trip_pwm_bench;
  localparam int CW = 16;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_in = 1'b0;
  logic [CW-1:0] period = 16'd20;
  logic [CW-1:0] duty = 16'd12;
  logic [BW-1:0] blank_len = 16'd4;
  logic pwm_out, limit_active, blank_active;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R9";

  always #5 clk = ~clk;

  peak_trip_pwm u_peak_trip_pwm (
    .clk(clk), .rst(rst), .trip_in(trip_in), .period(period), .duty(duty),
    .blank_len(blank_len), .pwm_out(pwm_out), .limit_active(limit_active),
    .blank_active(blank_active)
  );

  typedef struct {
    string tag;
    logic  pwm;
    logic  lim;
    logic  blk;
  } exp_t;
  exp_t sb[$];

  // Reference state, described per cycle: position, window left, sync taps, latch.
  int m_pos = 0, m_left = 0;
  bit m_was_high = 0, m_t1 = 0, m_t2 = 0, m_t3 = 0, m_arm = 0, m_lim = 0;

  // Model: at each falling edge predict outputs, then advance to the state after the next rising edge.
  always @(negedge clk) begin
    int  endpos;
    bit  high, opening, win, tripped, falling, take;
    exp_t e;
    endpos  = (period <= 1) ? 0 : int'(period) - 1;
    high    = m_pos < int'(duty);
    opening = high && !m_was_high;
    win     = high && (opening ? (blank_len != 0) : (m_left > 0));
    e.tag = cur_tag; e.pwm = high && !m_lim; e.lim = m_lim; e.blk = win;
    sb.push_back(e);
    if (rst) begin
      m_pos = 0; m_left = 0; m_was_high = 0;
      m_t1 = 0; m_t2 = 0; m_t3 = 0; m_arm = 0; m_lim = 0;
    end else begin
      tripped = m_t2;
      falling = m_t3 && !m_t2;
      take    = tripped && !win;
      if (take) m_lim = 1;
      else if (m_pos >= endpos && m_arm) m_lim = 0;
      if (falling) m_arm = 1;
      else if (m_pos == 0) m_arm = 0;
      if (!high) m_left = 0;
      else if (opening) m_left = (blank_len == 0) ? 0 : int'(blank_len) - 1;
      else if (m_left > 0) m_left = m_left - 1;
      m_was_high = high;
      m_t3 = m_t2; m_t2 = m_t1; m_t1 = trip_in;
      m_pos = (m_pos >= endpos) ? 0 : m_pos + 1;
    end
  end

  // Monitor: pop expected item and compare against the ports.
  always @(negedge clk) begin
    exp_t e;
    #1;
    while (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      checks++;
      if (pwm_out !== e.pwm) begin
        failures++;
        $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", e.tag, pwm_out, e.pwm, $time);
      end
      if (limit_active !== e.lim) begin
        failures++;
        $display("FAIL %s limit_active actual=%b expected=%b t=%0t", e.tag, limit_active, e.lim, $time);
      end
      if (blank_active !== e.blk) begin
        failures++;
        $display("FAIL %s blank_active actual=%b expected=%b t=%0t", e.tag, blank_active, e.blk, $time);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wait_pos(input int p);
    step(1);
    while (m_pos != p) step(1);
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: reset state and first cycle
    step(3);
    rst = 1'b0;
    cur_tag = "R9";
    step(2);
    // R1 and R2: plain cycles, no trip
    cur_tag = "R1";
    step(40);
    // R3: trip pulse lives only inside the blanking window
    cur_tag = "R3";
    wait_pos(19);
    trip_in = 1'b1; step(2); trip_in = 1'b0;
    step(30);
    // R4 R5 R6 R7: mid-phase pulse, latch, release at the boundary
    cur_tag = "R4";
    wait_pos(5);
    trip_in = 1'b1; step(3); trip_in = 1'b0;
    cur_tag = "R5";
    step(10);
    cur_tag = "R6";
    step(30);
    // R8: trip held across the end of the cycle
    cur_tag = "R8";
    wait_pos(6);
    trip_in = 1'b1;
    wait_pos(4);
    trip_in = 1'b0;
    cur_tag = "R7";
    step(45);
    // R2: zero blanking accepts a trip at count 0
    cur_tag = "R2";
    blank_len = 16'd0;
    wait_pos(18);
    trip_in = 1'b1; step(2); trip_in = 1'b0;
    step(30);
    // R2: long window truncated by end of high phase
    blank_len = 16'd50;
    step(45);
    // R1: new period and duty, then degenerate period
    cur_tag = "R1";
    blank_len = 16'd3;
    period = 16'd7; duty = 16'd3;
    step(30);
    duty = 16'd0;
    step(15);
    period = 16'd1; duty = 16'd1;
    step(10);
    period = 16'd9; duty = 16'd9;
    wait_pos(2);
    trip_in = 1'b1; step(8); trip_in = 1'b0;
    cur_tag = "R6";
    step(30);
    step(2);
    finish_run();
  end
endmodule